// File: doc/BRIEF.md
# Bridge Channel Input Steering

This block routes four PWM inputs to four half-bridge gate-drive outputs, grouped as two pairs (channels 1/2 and 3/4). A 3-bit mode setting selects either a straight path, where each output follows its own input, or an inverting path, where the second half-bridge of each pair is driven from the complement of its input. In the inverting path, both inputs of a pair carry one shared PWM signal, so the two halves of the bridge switch in opposition. Mode codes with the top bit set are reserved.

Each pair has its own active-low reset. While a pair's reset is low, its outputs are at high impedance and all of its state is cleared. The mode setting is sampled while the pair is held in reset and is frozen once the reset is released. After release, a start gate keeps the pair's outputs at high impedance until its first input (channel 1 or channel 3) has shown 35 rising edges. Those edges are counted after a two-flop synchronizer. A ramp-enable input hands the outputs over to an external ramp sequencer, and while it is high the block keeps every output at high impedance. Each output is presented as a drive-enable bit and a level bit. Enable low means high impedance.

Top module: `bridge_steer`

## Requirements
- R1: In mode codes 000 and 001, every enabled output level equals its own input (bit 0 of every 4-bit bus is channel 1, bit 3 is channel 4).
- R2: In mode codes 010 and 011, enabled outputs at bits 1 and 3 equal the complement of their own inputs, and outputs at bits 0 and 2 follow their inputs.
- R3: When the captured mode code has bit 2 set (codes 100 to 111), all four drive enables stay low.
- R4: When a pair reset input is low, that pair's two drive enables are low in the same cycle, without waiting for a clock edge; the other pair is unaffected.
- R5: A low pair reset clears that pair's edge count, so after the reset is released again the full 35 edges are needed before the pair drives.
- R6: After a pair reset is released, the pair's gate_ready output and drive enables stay low until 35 rising edges of the pair's first input (bit 0 or bit 2) have been counted; they go high after the 35th.
- R7: The mode is sampled while the pair reset is low; a change on mode_i while the reset is high has no effect on the outputs.
- R8: While ramp_en_i is high, all drive enables are low.
- R9: An output whose drive enable is low has its level bit at 0.
- R10: The edge counter saturates, and further input edges keep gate_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| pwm_i | input | 4 | PWM inputs, bit 0 = channel 1 |
| mode_i | input | 3 | Mode code, bit 2 set = reserved |
| pair_rst_ni | input | 2 | Active-low reset per pair, bit 0 = channels 1/2 |
| ramp_en_i | input | 1 | High hands outputs to the external ramp sequencer |
| drv_en_o | output | 4 | Drive enable per half-bridge, low = high impedance |
| drv_lvl_o | output | 4 | Gate level per half-bridge |
| gate_ready_o | output | 2 | Start gate open per pair |

## Verification
The bench stops one edge short of the start count and checks that the outputs are still off. A counter that is off by one, or that counts raw instead of synchronized edges, would open the gate at the wrong time. It drops a single pair reset and, with no clock, checks that only that pair goes to high impedance, then checks that the count restarts from zero; a design holding state across reset would drive after too few edges. It changes the mode while the pairs run, drives reserved codes, and asserts ramp enable. These catch a live-decoded mode that flips polarity in service, a reserved code that leaks through as straight or inverted drive, and a ramp hand-off that leaves the outputs driven.

// File: rtl/bs_pkg.sv
package bs_pkg;
  localparam int unsigned MODE_W = 3;

  typedef struct packed {
    logic reserved;
    logic invert;
  } path_cfg_t;

  function automatic path_cfg_t decode_mode(logic [MODE_W-1:0] m);
    path_cfg_t c;
    c.reserved = m[2];
    c.invert   = ~m[2] & m[1];
    return c;
  endfunction
endpackage

// File: rtl/bs_sync.sv
module bs_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bs_start_gate.sv
module bs_start_gate #(
  parameter int unsigned EDGES       = 35,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  output logic ready_o
);
  localparam int unsigned CNT_W = $clog2(EDGES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(EDGES);

  logic             pwm_s, pwm_prev_q, rise;
  logic [CNT_W-1:0] cnt_q;

  bs_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pwm_i),
    .q_o   (pwm_s)
  );

  assign rise = pwm_s & ~pwm_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_prev_q <= 1'b0;
      cnt_q      <= '0;
    end else begin
      pwm_prev_q <= pwm_s;
      if (rise && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/bs_pair_path.sv
module bs_pair_path
  import bs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pair_arst_ni,
  input  logic              pair_rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [1:0]        pwm_i,
  input  logic              ramp_en_i,
  input  logic              ready_i,
  output logic [1:0]        en_o,
  output logic [1:0]        lvl_o,
  output logic [MODE_W-1:0] mode_q_o
);
  logic              live;
  logic [MODE_W-1:0] mode_q;
  path_cfg_t         cfg;
  logic              drive;

  // release synchronizer: live rises SYNC_STAGES clocks after pair reset release
  bs_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_rel (
    .clk_i (clk_i),
    .rst_ni(pair_arst_ni),
    .d_i   (1'b1),
    .q_o   (live)
  );

  // mode tracks input while the pair is held, frozen once live
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= '0;
    else if (!live) mode_q <= mode_i;
  end

  assign cfg   = decode_mode(mode_q);
  assign drive = pair_rst_ni & live & ready_i & ~cfg.reserved & ~ramp_en_i;

  assign en_o     = {2{drive}};
  assign lvl_o[0] = drive & pwm_i[0];
  assign lvl_o[1] = drive & (pwm_i[1] ^ cfg.invert);
  assign mode_q_o = mode_q;
endmodule

// File: rtl/bridge_steer.sv
module bridge_steer
  import bs_pkg::*;
#(
  parameter int unsigned NUM_PAIRS   = 2,
  parameter int unsigned START_EDGES = 35,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_CH     = 2 * NUM_PAIRS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pwm_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [NUM_PAIRS-1:0] pair_rst_ni,
  input  logic              ramp_en_i,
  output logic [NUM_CH-1:0] drv_en_o,
  output logic [NUM_CH-1:0] drv_lvl_o,
  output logic [NUM_PAIRS-1:0] gate_ready_o
);
  logic [NUM_PAIRS-1:0]             pair_arst_n;
  logic [NUM_PAIRS-1:0][MODE_W-1:0] mode_q;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    logic       ready;
    logic [1:0] en, lvl;

    assign pair_arst_n[p] = rst_ni & pair_rst_ni[p];

    bs_start_gate #(.EDGES(START_EDGES), .SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk_i  (clk_i),
      .rst_ni (pair_arst_n[p]),
      .pwm_i  (pwm_i[2*p]),
      .ready_o(ready)
    );

    bs_pair_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pair_arst_ni(pair_arst_n[p]),
      .pair_rst_ni (pair_rst_ni[p]),
      .mode_i      (mode_i),
      .pwm_i       (pwm_i[2*p+1:2*p]),
      .ramp_en_i   (ramp_en_i),
      .ready_i     (ready),
      .en_o        (en),
      .lvl_o       (lvl),
      .mode_q_o    (mode_q[p])
    );

    assign drv_en_o[2*p+1:2*p]  = en;
    assign drv_lvl_o[2*p+1:2*p] = lvl;
    assign gate_ready_o[p]      = ready;
  end
endmodule

// File: rtl/bridge_steer_chk.sv
module bridge_steer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] pwm_i,
  input logic [1:0] pair_rst_ni,
  input logic       ramp_en_i,
  input logic [3:0] drv_en_o,
  input logic [3:0] drv_lvl_o,
  input logic [1:0] gate_ready_o,
  input logic [2:0] mode_q0,
  input logic [2:0] mode_q1
);
  p_straight_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o[1] && mode_q0[2:1] == 2'b00) |-> drv_lvl_o[1] == pwm_i[1]);

  p_invert_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o[3] && mode_q1[2:1] == 2'b01) |-> drv_lvl_o[3] != pwm_i[3]);

  p_reserved_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q0[2] |-> drv_en_o[1:0] == 2'b00) and (mode_q1[2] |-> drv_en_o[3:2] == 2'b00));

  p_hiz_rst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pair_rst_ni[0] |-> drv_en_o[1:0] == 2'b00) and (!pair_rst_ni[1] |-> drv_en_o[3:2] == 2'b00));

  p_en_needs_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o[0] |-> gate_ready_o[0]) and (drv_en_o[2] |-> gate_ready_o[1]));

  p_mode_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_ready_o[0] && pair_rst_ni[0] && $past(pair_rst_ni[0]) && $past(gate_ready_o[0]))
      |-> $stable(mode_q0));

  p_ramp_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_en_i |-> drv_en_o == 4'b0000);

  p_lvl_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_lvl_o & ~drv_en_o) == 4'b0000);

  p_ready_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_ready_o[0] && pair_rst_ni[0]) |=> (gate_ready_o[0] || !pair_rst_ni[0]));
endmodule

bind bridge_steer bridge_steer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pwm_i       (pwm_i),
  .pair_rst_ni (pair_rst_ni),
  .ramp_en_i   (ramp_en_i),
  .drv_en_o    (drv_en_o),
  .drv_lvl_o   (drv_lvl_o),
  .gate_ready_o(gate_ready_o),
  .mode_q0     (mode_q[0]),
  .mode_q1     (mode_q[1])
);

// File: tb/bridge_steer_tb_top.sv
module bridge_steer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] pwm;
  logic [2:0] mode;
  logic [1:0] prst_n;
  logic       ramp;
  logic [3:0] en, lvl;
  logic [1:0] rdy;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bridge_steer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .mode_i(mode),
    .pair_rst_ni(prst_n), .ramp_en_i(ramp),
    .drv_en_o(en), .drv_lvl_o(lvl), .gate_ready_o(rdy)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // rising edges on the first input of each pair selected by msk (bit0 -> ch1, bit2 -> ch3)
  task automatic pulses(logic [3:0] msk, int n);
    for (int i = 0; i < n; i++) begin
      pwm = pwm | msk; tick(4);
      pwm = pwm & ~msk; tick(4);
    end
  endtask

  task automatic bring_up(logic [2:0] m);
    prst_n = 2'b00; pwm = 4'h0; mode = m; tick(3);
    prst_n = 2'b11; tick(1);
    pulses(4'b0101, 35);
    tick(2);
  endtask

  task automatic patterns(string req, logic [3:0] inv, logic [3:0] exp_en);
    logic [3:0] pats [4] = '{4'h0, 4'hF, 4'h5, 4'hA};
    for (int i = 0; i < 4; i++) begin
      pwm = pats[i]; @(negedge clk);
      check(req, {4'h0, en}, {4'h0, exp_en});
      check(req, {4'h0, lvl}, {4'h0, (pats[i] ^ inv) & exp_en});
    end
    pwm = 4'h0; tick(1);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check("R4 en in reset", {4'h0, en}, 8'h00);
    check("R9 lvl in reset", {4'h0, lvl}, 8'h00);
    check("R6 ready in reset", {6'h0, rdy}, 8'h00);
  endtask

  task automatic t_start_gate;
    prst_n = 2'b00; pwm = 4'h0; mode = 3'b000; tick(3);
    prst_n = 2'b11; tick(1);
    pulses(4'b0101, 34); tick(2);
    @(negedge clk);
    check("R6 ready after 34", {6'h0, rdy}, 8'h00);
    check("R6 en after 34", {4'h0, en}, 8'h00);
    pulses(4'b0101, 1); tick(2);
    @(negedge clk);
    check("R6 ready after 35", {6'h0, rdy}, 8'h03);
    check("R6 en after 35", {4'h0, en}, 8'h0F);
  endtask

  task automatic t_straight;
    patterns("R1 straight 000", 4'h0, 4'hF);
  endtask

  task automatic t_saturate;
    pulses(4'b0101, 10); tick(2);
    @(negedge clk);
    check("R10 ready after extra edges", {6'h0, rdy}, 8'h03);
  endtask

  task automatic t_mode_frozen;
    mode = 3'b010; tick(3);
    patterns("R7 mode change ignored", 4'h0, 4'hF);
    mode = 3'b111; tick(3);
    patterns("R7 reserved change ignored", 4'h0, 4'hF);
  endtask

  task automatic t_pair_reset;
    @(negedge clk);
    prst_n = 2'b10; #1;
    check("R4 pair0 off at once", {4'h0, en}, 8'h0C);
    tick(2);
    prst_n = 2'b11; tick(1);
    pulses(4'b0001, 34); tick(2);
    @(negedge clk);
    check("R5 pair0 count restarted", {6'h0, rdy}, 8'h02);
    pulses(4'b0001, 1); tick(2);
    @(negedge clk);
    check("R5 pair0 ready again", {6'h0, rdy}, 8'h03);
  endtask

  task automatic t_invert;
    bring_up(3'b010);
    patterns("R2 invert 010", 4'hA, 4'hF);
    bring_up(3'b011);
    patterns("R2 invert 011", 4'hA, 4'hF);
    bring_up(3'b001);
    patterns("R1 straight 001", 4'h0, 4'hF);
  endtask

  task automatic t_reserved;
    bring_up(3'b100);
    @(negedge clk);
    check("R3 ready still counts", {6'h0, rdy}, 8'h03);
    patterns("R3 reserved 100", 4'h0, 4'h0);
    bring_up(3'b110);
    patterns("R3 reserved 110", 4'h0, 4'h0);
  endtask

  task automatic t_ramp;
    bring_up(3'b000);
    ramp = 1'b1; tick(1);
    patterns("R8 ramp holds off", 4'h0, 4'h0);
    ramp = 1'b0; tick(1);
    patterns("R8 ramp released", 4'h0, 4'hF);
  endtask

  initial begin
    rst_n = 1'b0; pwm = 4'h0; mode = 3'b000; prst_n = 2'b00; ramp = 1'b0;
    tick(3);
    t_reset_state;
    rst_n = 1'b1; tick(2);
    t_reset_state;
    t_start_gate;
    t_straight;
    t_saturate;
    t_mode_frozen;
    t_pair_reset;
    t_invert;
    t_reserved;
    t_ramp;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_err);
      $finish;
    end
  end
endmodule